// File: doc/BRIEF.md
# Coprocessor Busy-Cycle Stall Tracker

This block sits beside the issue stage of a host CPU that drives a geometry coprocessor. Each time the host issues a coprocessor command, the block reports how many cycles the host must wait before that command can start. It also records when the coprocessor will next be free. The host supplies its own free-running cycle count on every cycle. The block keeps one timestamp, `busy_until`, which marks the cycle at which the coprocessor finishes its current work.

When a command is issued, the block subtracts the current cycle from `busy_until` using modular arithmetic. If the difference is at most 44 cycles, the command stalls for exactly that many cycles and starts at `busy_until`. If the difference is larger, the timestamp is treated as already in the past, even across a counter wrap, so no stall occurs and the command starts at once. The timestamp then advances to the effective start cycle plus the latency of the new command. That latency is read from a fixed table indexed by the command's 6-bit function code.

Top module: `cst_stall_tracker`

## Requirements
- R1: While `rst_n` is low, the block loads `busy_until` with `cycle_i`, and drives `stall_o`, `stall_vld_o` and `busy_o` to 0. The first command issued at the reset cycle value therefore does not stall.
- R2: The latency table has 64 entries indexed by `func_i` (6 bits). Codes 0x01=15, 0x06=8, 0x0C=6, 0x10=8, 0x11=8, 0x12=8, 0x13=19, 0x14=13, 0x16=44, 0x1B=17, 0x1C=11, 0x1E=14, 0x20=30, 0x28=5, 0x29=8, 0x2A=17, 0x2D=5, 0x2E=6, 0x30=23, 0x3D=5, 0x3E=5 and 0x3F=39 carry the listed latencies. Every other code has latency 0.
- R3: The remaining time is `busy_until - cycle_i`, taken modulo 2^32. When it is at most 44, the stall reported for the issue equals the remaining time, including the boundary value 44.
- R4: When the remaining time exceeds 44, the stall is 0 and the command starts at `cycle_i`.
- R5: After an issue, `busy_until` becomes the effective start cycle plus the command's latency. The effective start cycle is `busy_until` when the command stalled and `cycle_i` otherwise, so stalled commands chain back to back.
- R6: The remaining-time test is wrap-safe. A `busy_until` that has wrapped past zero still produces the correct stall, and a timestamp one cycle in the past reads as idle.
- R7: `busy_o` is high exactly when the remaining time is between 1 and 44 inclusive. It is a combinational function of the current `cycle_i`.
- R8: `stall_o` and `stall_vld_o` are registered and appear one cycle after the issue strobe. `stall_vld_o` is a single-cycle pulse for each issue, and `stall_o` is 0 in every cycle where `stall_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Command issue strobe, one cycle per command |
| func_i | input | 6 | Function code of the issued command |
| cycle_i | input | 32 | Host's current cycle count |
| stall_o | output | 6 | Stall cycles owed by the last issued command |
| stall_vld_o | output | 1 | One-cycle pulse qualifying `stall_o` |
| busy_o | output | 1 | Coprocessor still busy at `cycle_i` |

## Verification
The assertions check the following on every cycle:
- the stall never exceeds the 44-cycle window;
- the valid pulse tracks the issue strobe exactly one cycle later;
- `stall_o` is zero outside a valid pulse;
- an issue made while `busy_o` is low reports no stall, and an issue made while it is high reports a nonzero stall.

The exact values can only be shown by the bench's scenarios. These cover each latency table entry, the 44 boundary, the idle reading of a timestamp more than 44 cycles ahead, chained stalls, and the counter wrap.

// File: rtl/cst_pkg.sv
// Package: shared parameters and the per-opcode latency function for the
// stall tracker. Assumes a 6-bit function code and a 32-bit cycle count.
package cst_pkg;
    localparam int CST_FUNC_W   = 6;
    localparam int CST_LAT_W    = 6;
    localparam int CST_CYC_W    = 32;
    localparam int CST_MAX_WAIT = 44;

    // Return the busy latency of one command code (0 for unlisted codes).
    function automatic logic [CST_LAT_W-1:0] cst_latency(input logic [CST_FUNC_W-1:0] code);
        logic [CST_LAT_W-1:0] lat;
        case (code)
            6'h01: lat = 6'd15;
            6'h06: lat = 6'd8;
            6'h0C: lat = 6'd6;
            6'h10: lat = 6'd8;
            6'h11: lat = 6'd8;
            6'h12: lat = 6'd8;
            6'h13: lat = 6'd19;
            6'h14: lat = 6'd13;
            6'h16: lat = 6'd44;
            6'h1B: lat = 6'd17;
            6'h1C: lat = 6'd11;
            6'h1E: lat = 6'd14;
            6'h20: lat = 6'd30;
            6'h28: lat = 6'd5;
            6'h29: lat = 6'd8;
            6'h2A: lat = 6'd17;
            6'h2D: lat = 6'd5;
            6'h2E: lat = 6'd6;
            6'h30: lat = 6'd23;
            6'h3D: lat = 6'd5;
            6'h3E: lat = 6'd5;
            6'h3F: lat = 6'd39;
            default: lat = '0;
        endcase
        return lat;
    endfunction
endpackage

// File: rtl/cst_lat_rom.sv
// Module: latency lookup. Builds a constant table with one entry per
// function code and selects the entry for the incoming code.
// Assumes FUNC_W matches the width understood by cst_latency.
module cst_lat_rom
    import cst_pkg::*;
#(
    parameter int FUNC_W = CST_FUNC_W,
    parameter int LAT_W  = CST_LAT_W
) (
    input  logic [FUNC_W-1:0] func_i,
    output logic [LAT_W-1:0]  lat_o
);
    localparam int DEPTH = 1 << FUNC_W;

    logic [LAT_W-1:0] table_q [DEPTH];

    // One constant entry per function code.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign table_q[g] = LAT_W'(cst_latency(CST_FUNC_W'(g)));
    end

    // Select the latency of the issued code.
    assign lat_o = table_q[func_i];
endmodule

// File: rtl/cst_wait_calc.sv
// Module: wrap-safe remaining-time evaluation. From the stored busy
// timestamp and the current cycle it derives the stall, the effective start
// cycle and the busy flag. Purely combinational.
// Assumes MAX_WAIT fits in STALL_W bits.
module cst_wait_calc
    import cst_pkg::*;
#(
    parameter int CYC_W    = CST_CYC_W,
    parameter int STALL_W  = CST_LAT_W,
    parameter int MAX_WAIT = CST_MAX_WAIT
) (
    input  logic [CYC_W-1:0]   busy_until_i,
    input  logic [CYC_W-1:0]   cycle_i,
    output logic [STALL_W-1:0] wait_o,
    output logic [CYC_W-1:0]   start_o,
    output logic               busy_o
);
    localparam logic [CYC_W-1:0] LIMIT = CYC_W'(MAX_WAIT);

    logic [CYC_W-1:0] left;
    logic             in_window;

    // Modular distance to the busy timestamp and the window test.
    always_comb begin
        left      = busy_until_i - cycle_i;
        in_window = (left <= LIMIT);
    end

    // Stall amount, effective start cycle and busy flag.
    always_comb begin
        wait_o  = in_window ? left[STALL_W-1:0] : '0;
        start_o = in_window ? busy_until_i : cycle_i;
        busy_o  = in_window && (left != '0);
    end
endmodule

// File: rtl/cst_stall_tracker.sv
// Module: top of the coprocessor stall tracker. Holds the busy timestamp,
// registers the stall reported for each issued command and exposes a
// combinational busy flag. Assumes the host's cycle count advances by at most
// one per clock and that issue_i is a single-cycle strobe per command.
module cst_stall_tracker
    import cst_pkg::*;
#(
    parameter int FUNC_W   = CST_FUNC_W,
    parameter int CYC_W    = CST_CYC_W,
    parameter int STALL_W  = CST_LAT_W,
    parameter int MAX_WAIT = CST_MAX_WAIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  logic [FUNC_W-1:0]  func_i,
    input  logic [CYC_W-1:0]   cycle_i,
    output logic [STALL_W-1:0] stall_o,
    output logic               stall_vld_o,
    output logic               busy_o
);
    localparam int LAT_W = STALL_W;

    logic [CYC_W-1:0]   busy_until_q;
    logic [STALL_W-1:0] stall_q;
    logic               vld_q;
    logic [LAT_W-1:0]   lat;
    logic [STALL_W-1:0] wait_amt;
    logic [CYC_W-1:0]   start_cyc;
    logic [CYC_W-1:0]   next_busy;

    cst_lat_rom #(.FUNC_W(FUNC_W), .LAT_W(LAT_W)) u_rom (
        .func_i (func_i),
        .lat_o  (lat)
    );

    cst_wait_calc #(.CYC_W(CYC_W), .STALL_W(STALL_W), .MAX_WAIT(MAX_WAIT)) u_calc (
        .busy_until_i (busy_until_q),
        .cycle_i      (cycle_i),
        .wait_o       (wait_amt),
        .start_o      (start_cyc),
        .busy_o       (busy_o)
    );

    // Timestamp the coprocessor becomes free after the issued command.
    always_comb next_busy = start_cyc + CYC_W'(lat);

    // Update the timestamp and register the per-issue stall report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_until_q <= cycle_i;
            stall_q      <= '0;
            vld_q        <= 1'b0;
        end else begin
            vld_q <= issue_i;
            if (issue_i) begin
                stall_q      <= wait_amt;
                busy_until_q <= next_busy;
            end else begin
                stall_q <= '0;
            end
        end
    end

    assign stall_o     = stall_q;
    assign stall_vld_o = vld_q;
endmodule

// File: rtl/cst_stall_checker.sv
// Module: protocol checker for the stall tracker, bound to the top module.
// Observes ports only.
module cst_stall_checker #(
    parameter int STALL_W  = 6,
    parameter int MAX_WAIT = 44
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_i,
    input logic [STALL_W-1:0] stall_o,
    input logic               stall_vld_o,
    input logic               busy_o
);
    AST_STALL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o <= STALL_W'(MAX_WAIT)); // R3
    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !busy_o) |=> (stall_o == '0)); // R4
    AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && busy_o) |=> (stall_o != '0)); // R7
    AST_VLD_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> stall_vld_o); // R8
    AST_VLD_ONLY_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> !stall_vld_o); // R8
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_vld_o |-> (stall_o == '0)); // R8
endmodule

bind cst_stall_tracker cst_stall_checker #(.STALL_W(STALL_W), .MAX_WAIT(MAX_WAIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue_i),
    .stall_o     (stall_o),
    .stall_vld_o (stall_vld_o),
    .busy_o      (busy_o)
);

// File: tb/tb_cst_stall_tracker.sv
// Directed bench for the stall tracker: one task per scenario.
module tb_cst_stall_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [5:0]  func_i = '0;
    logic [31:0] cycle_i = 32'd100;
    logic [5:0]  stall_o;
    logic        stall_vld_o;
    logic        busy_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk; // 250 MHz

    cst_stall_tracker dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .func_i(func_i),
        .cycle_i(cycle_i), .stall_o(stall_o), .stall_vld_o(stall_vld_o),
        .busy_o(busy_o)
    );

    // Expected latency per code, taken from the requirement text.
    function automatic int exp_lat(input int c);
        case (c)
            'h01: return 15; 'h06: return 8;  'h0C: return 6;  'h10: return 8;
            'h11: return 8;  'h12: return 8;  'h13: return 19; 'h14: return 13;
            'h16: return 44; 'h1B: return 17; 'h1C: return 11; 'h1E: return 14;
            'h20: return 30; 'h28: return 5;  'h29: return 8;  'h2A: return 17;
            'h2D: return 5;  'h2E: return 6;  'h30: return 23; 'h3D: return 5;
            'h3E: return 5;  'h3F: return 39;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Issue one command at a given cycle; check stall, pulse and quiet cycle.
    task automatic issue(input logic [5:0] f, input logic [31:0] cyc, input int exp_stall, input string req);
        @(negedge clk);
        issue_i = 1'b1; func_i = f; cycle_i = cyc;
        @(negedge clk);
        issue_i = 1'b0;
        check(req, "stall", stall_o, exp_stall);
        check("R8", "valid pulse", stall_vld_o, 1);
        @(negedge clk);
        check("R8", "valid drops", stall_vld_o, 0);
        check("R8", "stall quiet", stall_o, 0);
    endtask

    // Move the host cycle without issuing and check the busy flag.
    task automatic probe_busy(input logic [31:0] cyc, input int exp_busy, input string req);
        @(negedge clk);
        cycle_i = cyc;
        #1;
        check(req, "busy", busy_o, exp_busy);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "stall at reset", stall_o, 0);
        check("R1", "valid at reset", stall_vld_o, 0);
        check("R1", "busy at reset", busy_o, 0);
        @(negedge clk); rst_n = 1'b1;
        issue(6'h01, 32'd100, 0, "R1");
        probe_busy(32'd100, 1, "R7");
    endtask

    task automatic t_table();
        for (int c = 0; c < 64; c++) begin
            logic [31:0] base = 32'd1000 + 32'(c) * 32'd100;
            issue(6'(c), base, 0, "R4");
            probe_busy(base, exp_lat(c) != 0, "R7");
            issue(6'(c), base, exp_lat(c), "R2");
        end
    endtask

    task automatic t_beyond_window();
        logic [31:0] b = 32'h0001_0000;
        issue(6'h16, b, 0, "R4");
        issue(6'h16, b, 44, "R3");
        probe_busy(b, 0, "R7");
        issue(6'h01, b, 0, "R4");
        probe_busy(b, 1, "R5");
        probe_busy(b + 32'd15, 0, "R5");
    endtask

    task automatic t_chain();
        logic [31:0] b = 32'h0002_0000;
        issue(6'h01, b, 0, "R4");
        issue(6'h13, b + 32'd5, 10, "R3");
        issue(6'h28, b + 32'd10, 24, "R5");
        probe_busy(b + 32'd38, 1, "R5");
        probe_busy(b + 32'd39, 0, "R5");
    endtask

    task automatic t_wrap();
        issue(6'h20, 32'hFFFF_FFF8, 0, "R6");
        issue(6'h28, 32'h0000_0002, 20, "R6");
        probe_busy(32'h0000_001A, 1, "R6");
        probe_busy(32'h0000_001C, 0, "R6");
        issue(6'h01, 32'h0000_001C, 0, "R6");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_table();
        t_beyond_window();
        t_chain();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule